// File: doc/BRIEF.md
# Hotplug Slot Status Register Block

This block holds per-bus slot status for a host that learns about device insertion and removal through a small register window. Each bus has 32 slots. Two side inputs report events: a plug event and an unplug request, each with a bus index and a slot number. Every accepted event sets one bit in that bus's status masks and produces a single-cycle interrupt pulse. Software then reads the masks to find out what changed.

The register window accepts only full 32-bit accesses. A select register chooses which bus the per-bus registers show. The inserted-slot mask clears itself when read. The removal-request mask stays set until software writes an eject mask for the selected bus. That write clears the matching request bits and sends a one-cycle eject strobe, with the bus index and the slot mask, to the logic that removes the device. A strap input puts the block in a legacy mode where the selection always stays on bus 0.

Top module: `hp_slot_regs`

## Requirements
- R1: The register offsets are: inserted mask at 0x00, removal-request mask at 0x04, eject at 0x08, removable mask at 0x0C, bus select at 0x10. Read data and `rsp_valid` appear in the cycle after the request. The eject register and unmapped offsets read as zero.
- R2: A request with `req_full` low is not a valid access. It reads zero and changes no state.
- R3: A read at 0x00 returns the selected bus's inserted mask and then clears that mask to zero.
- R4: A read at 0x04 returns the selected bus's removal-request mask and leaves it unchanged.
- R5: A plug event for slot n on bus b sets bit n of bus b's inserted mask. `irq` is high for exactly the following cycle.
- R6: An unplug request for slot n on bus b sets bit n of bus b's removal-request mask. `irq` is high for exactly the following cycle.
- R7: A write at 0x10 stores the written 32-bit value as the bus index. A read at 0x10 returns that value. The index is 0 after reset.
- R8: When `cfg_legacy` is high, a write at 0x10 stores 0 whatever the written value.
- R9: A write at 0x08 forms an effective mask: the write data ANDed with the selected bus's removable mask. The write clears those bits of the bus's removal-request mask. If the effective mask is non-zero, the next cycle shows `ej_valid` high for one cycle with `ej_bus` set to the bus and `ej_mask` set to the effective mask. If the effective mask is zero, there is no strobe.
- R10: A read at 0x0C returns the selected bus's removable mask. Every bus resets to the parameter `RMV_INIT` (default 0xFFFF_FFFE, so slot 0 is fixed). Writes to 0x0C are ignored.
- R11: When the bus index is not below `NUM_BUS`, reads at 0x00, 0x04 and 0x0C return zero and clear nothing. An eject write then has no effect and produces no strobe.
- R12: When an event sets a bit in the same cycle as a read or eject that clears the same mask, the set bit survives.
- R13: After reset, every mask except the removable mask is zero, and `irq`, `ej_valid` and `rsp_valid` are low.
- R14: An event whose bus index is not below `NUM_BUS` is dropped and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_legacy | input | 1 | Legacy strap: bus selection pinned to 0 |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | Access is a full 4-byte access |
| req_addr | input | 5 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a valid read) |
| rsp_rdata | output | 32 | Read data |
| plug_valid | input | 1 | Plug event |
| plug_bus | input | 8 | Bus index of plug event |
| plug_slot | input | 5 | Slot of plug event |
| unplug_valid | input | 1 | Unplug request event |
| unplug_bus | input | 8 | Bus index of unplug request |
| unplug_slot | input | 5 | Slot of unplug request |
| irq | output | 1 | One-cycle interrupt pulse |
| ej_valid | output | 1 | One-cycle eject strobe |
| ej_bus | output | 8 | Bus of the eject |
| ej_mask | output | 32 | Slots being ejected |

## Verification
Assertions check a set of rules on every cycle:
- An accepted event always raises `irq` on the next cycle, and a cycle with no event is always followed by a low `irq`.
- A set bit survives a clearing access in the same cycle.
- A read of the inserted mask with no event leaves that mask at zero.
- The removal-request mask stays stable when nothing sets or clears it.
- An eject strobe never carries an empty mask or an invalid bus.
- A legacy-mode select write lands on 0.

Some behaviours need the bench's scenarios to show them: the exact values read back through the selected bus, switching between buses, and the out-of-range index that hides all per-bus state. The same holds for ignored partial accesses, the removable-mask filtering of an eject, and dropped events on buses that do not exist.

// File: rtl/hp_pkg.sv
// Shared constants for the hotplug slot status block.
// Assumes a 32-bit register window with 5-bit byte offsets.
package hp_pkg;
    localparam int SLOT_N  = 32;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_UP   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DOWN = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_EJ   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RMV  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_SEL  = 5'h10;

    typedef logic [SLOT_N-1:0] slot_mask_t;
endpackage

// File: rtl/hp_reg_decode.sv
// Register access decoder and bus select register.
// Turns each valid full-width access into one-hot strobes, and holds the
// bus index. Assumes at most one access per cycle.
module hp_reg_decode
    import hp_pkg::*;
#(
    parameter int NUM_BUS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_legacy,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_full,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              acc_rd,
    output logic              rd_up,
    output logic              rd_down,
    output logic              rd_rmv,
    output logic              rd_sel,
    output logic              wr_ej,
    output logic [DATA_W-1:0] sel_q,
    output logic              sel_ok
);
    logic acc;
    logic wr_sel;

    // Qualify the request: only full 4-byte accesses count.
    always_comb begin
        acc     = req_valid && req_full;
        acc_rd  = acc && !req_write;
        rd_up   = acc_rd && (req_addr == OFS_UP);
        rd_down = acc_rd && (req_addr == OFS_DOWN);
        rd_rmv  = acc_rd && (req_addr == OFS_RMV);
        rd_sel  = acc_rd && (req_addr == OFS_SEL);
        wr_ej   = acc && req_write && (req_addr == OFS_EJ);
        wr_sel  = acc && req_write && (req_addr == OFS_SEL);
    end

    // Bus index register; legacy strap forces the default bus.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_sel)
            sel_q <= cfg_legacy ? '0 : req_wdata;
    end

    // The index addresses a real bus only when below the bus count.
    always_comb sel_ok = (sel_q < DATA_W'(NUM_BUS));

    AST_LEGACY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && cfg_legacy) |=> (sel_q == '0)); // R8
endmodule

// File: rtl/hp_bus_state.sv
// Status words for one bus: inserted mask, removal-request mask and
// removable mask. Set vectors take priority over clears in the same cycle.
// The removable mask is fixed at reset.
module hp_bus_state
    import hp_pkg::*;
#(
    parameter slot_mask_t RMV_INIT = 32'hFFFF_FFFE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slot_mask_t set_up,
    input  logic       clr_up,
    input  slot_mask_t set_dn,
    input  slot_mask_t clr_dn,
    output slot_mask_t up_q,
    output slot_mask_t dn_q,
    output slot_mask_t rmv_q
);
    // Inserted mask: cleared whole on read, new sets survive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            up_q <= '0;
        else
            up_q <= (clr_up ? '0 : up_q) | set_up;
    end

    // Removal-request mask: bits cleared by eject, new sets survive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dn_q <= '0;
        else
            dn_q <= (dn_q & ~clr_dn) | set_dn;
    end

    // Removable mask: strap value loaded at reset, then held.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rmv_q <= RMV_INIT;
    end

    AST_UP_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_up && set_up == '0) |=> (up_q == '0)); // R3
    AST_UP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_up != '0) |=> ((up_q & $past(set_up)) == $past(set_up))); // R12
    AST_DN_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_dn != '0) |=> ((dn_q & $past(set_dn)) == $past(set_dn))); // R12
    AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_dn == '0 && clr_dn == '0) |=> $stable(dn_q)); // R4
endmodule

// File: rtl/hp_slot_regs.sv
// Hotplug slot status register block (top).
// Builds one status set per bus, and routes events and register accesses
// to them. Registers read data, the interrupt pulse and the eject strobe.
// Assumes event inputs are synchronous to clk.
module hp_slot_regs
    import hp_pkg::*;
#(
    parameter int         NUM_BUS  = 4,
    parameter int         EV_BUS_W = 8,
    parameter slot_mask_t RMV_INIT = 32'hFFFF_FFFE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_legacy,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_full,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                plug_valid,
    input  logic [EV_BUS_W-1:0] plug_bus,
    input  logic [4:0]          plug_slot,
    input  logic                unplug_valid,
    input  logic [EV_BUS_W-1:0] unplug_bus,
    input  logic [4:0]          unplug_slot,
    output logic                irq,
    output logic                ej_valid,
    output logic [EV_BUS_W-1:0] ej_bus,
    output logic [DATA_W-1:0]   ej_mask
);
    localparam int BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;

    logic              acc_rd, rd_up, rd_down, rd_rmv, rd_sel, wr_ej, sel_ok;
    logic [DATA_W-1:0] sel_q;
    logic [BUS_W-1:0]  sel_idx;
    logic              plug_ok, unplug_ok;
    slot_mask_t        up_w  [NUM_BUS];
    slot_mask_t        dn_w  [NUM_BUS];
    slot_mask_t        rmv_w [NUM_BUS];
    slot_mask_t        ej_eff;
    logic [DATA_W-1:0] rd_mux;

    hp_reg_decode #(.NUM_BUS(NUM_BUS)) u_dec (
        .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .acc_rd(acc_rd), .rd_up(rd_up), .rd_down(rd_down), .rd_rmv(rd_rmv),
        .rd_sel(rd_sel), .wr_ej(wr_ej), .sel_q(sel_q), .sel_ok(sel_ok)
    );

    // Events aimed at buses that do not exist are dropped.
    always_comb begin
        plug_ok   = plug_valid   && (plug_bus   < EV_BUS_W'(NUM_BUS));
        unplug_ok = unplug_valid && (unplug_bus < EV_BUS_W'(NUM_BUS));
        sel_idx   = sel_q[BUS_W-1:0];
    end

    // One status set per bus with its own set and clear steering.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        logic       is_sel;
        slot_mask_t set_up, set_dn, clr_dn;
        always_comb begin
            is_sel = sel_ok && (sel_idx == BUS_W'(b));
            set_up = (plug_ok && plug_bus == EV_BUS_W'(b))
                   ? (slot_mask_t'(1) << plug_slot) : '0;
            set_dn = (unplug_ok && unplug_bus == EV_BUS_W'(b))
                   ? (slot_mask_t'(1) << unplug_slot) : '0;
            clr_dn = (wr_ej && is_sel) ? (req_wdata & rmv_w[b]) : '0;
        end
        hp_bus_state #(.RMV_INIT(RMV_INIT)) u_bus (
            .clk(clk), .rst_n(rst_n),
            .set_up(set_up), .clr_up(rd_up && is_sel),
            .set_dn(set_dn), .clr_dn(clr_dn),
            .up_q(up_w[b]), .dn_q(dn_w[b]), .rmv_q(rmv_w[b])
        );
    end

    // Read-data and effective-eject selection from the chosen bus.
    always_comb begin
        rd_mux = '0;
        ej_eff = '0;
        if (sel_ok) begin
            ej_eff = req_wdata & rmv_w[sel_idx];
            if (rd_up)   rd_mux = up_w[sel_idx];
            if (rd_down) rd_mux = dn_w[sel_idx];
            if (rd_rmv)  rd_mux = rmv_w[sel_idx];
        end
        if (rd_sel) rd_mux = sel_q;
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_rd;
            rsp_rdata <= acc_rd ? rd_mux : '0;
        end
    end

    // Interrupt pulse for any accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= plug_ok || unplug_ok;
    end

    // Eject strobe toward the device removal logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ej_valid <= 1'b0;
            ej_bus   <= '0;
            ej_mask  <= '0;
        end else begin
            ej_valid <= wr_ej && sel_ok && (ej_eff != '0);
            ej_bus   <= EV_BUS_W'(sel_idx);
            ej_mask  <= ej_eff;
        end
    end

    AST_IRQ_ON_PLUG: assert property (@(posedge clk) disable iff (!rst_n)
        (plug_valid && plug_bus < EV_BUS_W'(NUM_BUS)) |=> irq); // R5
    AST_IRQ_ON_UNPLUG: assert property (@(posedge clk) disable iff (!rst_n)
        (unplug_valid && unplug_bus < EV_BUS_W'(NUM_BUS)) |=> irq); // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!plug_valid && !unplug_valid) |=> !irq); // R14
    AST_EJ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ej_valid |-> (ej_mask != '0 && ej_bus < EV_BUS_W'(NUM_BUS))); // R9
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_full) |=> !rsp_valid); // R2
endmodule

// File: tb/sim_hp_slot_regs.sv
// Bench for hp_slot_regs: vector table walk, then directed corner tests.
module sim_hp_slot_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_legacy = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_full = 1'b1;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        plug_valid = 1'b0, unplug_valid = 1'b0;
    logic [7:0]  plug_bus = '0, unplug_bus = '0;
    logic [4:0]  plug_slot = '0, unplug_slot = '0;
    logic        irq, ej_valid;
    logic [7:0]  ej_bus;
    logic [31:0] ej_mask;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] rd;
    logic        s_irq, s_ej;
    logic [7:0]  s_ejb;
    logic [31:0] s_ejm;

    always #2.5 clk = ~clk;   // 200 MHz

    hp_slot_regs u0 (
        .clk(clk), .rst_n(rst_n), .cfg_legacy(cfg_legacy),
        .req_valid(req_valid), .req_write(req_write), .req_full(req_full),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
        .unplug_valid(unplug_valid), .unplug_bus(unplug_bus),
        .unplug_slot(unplug_slot),
        .irq(irq), .ej_valid(ej_valid), .ej_bus(ej_bus), .ej_mask(ej_mask)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs sampled at the following negedge.
    task automatic cyc(input logic rv, input logic wr, input logic full,
                       input logic [4:0] a, input logic [31:0] wd,
                       input logic pv, input logic [7:0] pb, input logic [4:0] ps,
                       input logic uv, input logic [7:0] ub, input logic [4:0] us);
        @(negedge clk);
        req_valid = rv; req_write = wr; req_full = full;
        req_addr = a; req_wdata = wd;
        plug_valid = pv; plug_bus = pb; plug_slot = ps;
        unplug_valid = uv; unplug_bus = ub; unplug_slot = us;
        @(negedge clk);
        rd = rsp_rdata; s_irq = irq; s_ej = ej_valid; s_ejb = ej_bus; s_ejm = ej_mask;
        req_valid = 1'b0; plug_valid = 1'b0; unplug_valid = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a);
        cyc(1, 0, 1, a, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        cyc(1, 1, 1, a, d, 0, 0, 0, 0, 0, 0);
    endtask

    // op: 0 read+compare, 1 write, 2 plug, 3 unplug (data[15:8]=bus, data[4:0]=slot)
    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 5'h00, 32'h0000_0003, 32'h1, 8'd5 },  // R5 plug bus0 slot3
        '{2'd0, 5'h00, 32'h0,         32'h0000_0008, 8'd3 }, // R3 read UP
        '{2'd0, 5'h00, 32'h0,         32'h0, 8'd3 },  // R3 cleared
        '{2'd2, 5'h00, 32'h0000_011F, 32'h1, 8'd5 },  // R5 plug bus1 slot31
        '{2'd1, 5'h10, 32'h1,         32'h0, 8'd7 },  // R7 select bus1
        '{2'd0, 5'h10, 32'h0,         32'h1, 8'd7 },  // R7 readback
        '{2'd0, 5'h00, 32'h0,         32'h8000_0000, 8'd3 }, // R3 bus1 UP
        '{2'd3, 5'h00, 32'h0000_0105, 32'h1, 8'd6 },  // R6 unplug bus1 slot5
        '{2'd0, 5'h04, 32'h0,         32'h0000_0020, 8'd4 }, // R4 DOWN
        '{2'd0, 5'h04, 32'h0,         32'h0000_0020, 8'd4 }, // R4 not cleared
        '{2'd0, 5'h0C, 32'h0,         32'hFFFF_FFFE, 8'd10}, // R10 removable
        '{2'd0, 5'h08, 32'h0,         32'h0, 8'd1 }   // R1 eject reads zero
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 irq", {31'b0, irq}, 0);
        chk("R13 ej_valid", {31'b0, ej_valid}, 0);
        chk("R13 rsp_valid", {31'b0, rsp_valid}, 0);
        rst_n = 1'b1;
        rd_reg(5'h00); chk("R13 UP after reset", rd, 0);
        chk("R1 rsp_valid on read", {31'b0, rsp_valid}, 1);
        rd_reg(5'h10); chk("R13 SELECT after reset", rd, 0);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            case (VECS[i].op)
                2'd0: begin
                    rd_reg(VECS[i].addr);
                    chk($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
                end
                2'd1: wr_reg(VECS[i].addr, VECS[i].data);
                2'd2: begin
                    cyc(0, 0, 1, 0, 0, 1, VECS[i].data[15:8], VECS[i].data[4:0], 0, 0, 0);
                    chk($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, s_irq}, VECS[i].exp);
                end
                default: begin
                    cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, VECS[i].data[15:8], VECS[i].data[4:0]);
                    chk($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, s_irq}, VECS[i].exp);
                end
            endcase
        end

        // R5 pulse lasts one cycle only
        @(negedge clk); chk("R5 irq single cycle", {31'b0, irq}, 0);

        // R11 out-of-range select hides state and blocks eject
        wr_reg(5'h10, 32'd9);
        rd_reg(5'h04); chk("R11 DOWN out of range", rd, 0);
        rd_reg(5'h0C); chk("R11 removable out of range", rd, 0);
        wr_reg(5'h08, 32'h20); chk("R11 no eject strobe", {31'b0, s_ej}, 0);
        wr_reg(5'h10, 32'd1);
        rd_reg(5'h04); chk("R11 DOWN untouched", rd, 32'h20);

        // R9 eject filtered by removable mask; slot0 not removable
        wr_reg(5'h08, 32'h21);
        chk("R9 eject strobe", {31'b0, s_ej}, 1);
        chk("R9 eject bus", {24'b0, s_ejb}, 1);
        chk("R9 eject mask", s_ejm, 32'h20);
        @(negedge clk); chk("R9 strobe one cycle", {31'b0, ej_valid}, 0);
        rd_reg(5'h04); chk("R9 DOWN cleared", rd, 0);
        wr_reg(5'h08, 32'h1); chk("R9 no strobe for fixed slot", {31'b0, s_ej}, 0);

        // R10 writes to removable ignored
        wr_reg(5'h0C, 32'h0);
        rd_reg(5'h0C); chk("R10 removable unchanged", rd, 32'hFFFF_FFFE);

        // R2 partial accesses ignored
        cyc(0, 0, 1, 0, 0, 1, 8'd1, 5'd2, 0, 0, 0);
        cyc(1, 0, 0, 5'h00, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 partial read zero", rd, 0);
        chk("R2 partial read no rsp", {31'b0, rsp_valid}, 0);
        cyc(1, 1, 0, 5'h10, 32'd3, 0, 0, 0, 0, 0, 0);
        rd_reg(5'h10); chk("R2 partial write ignored", rd, 1);
        rd_reg(5'h00); chk("R2 UP not cleared", rd, 32'h4);

        // R12 set beats read clear in same cycle
        cyc(0, 0, 1, 0, 0, 1, 8'd1, 5'd2, 0, 0, 0);
        cyc(1, 0, 1, 5'h00, 0, 1, 8'd1, 5'd7, 0, 0, 0);
        chk("R12 read returns old", rd, 32'h4);
        rd_reg(5'h00); chk("R12 new bit survives", rd, 32'h80);
        // R12 unplug set beats eject clear
        cyc(0, 0, 1, 0, 0, 0, 0, 0, 1, 8'd1, 5'd9);
        cyc(1, 1, 1, 5'h08, 32'h200, 0, 0, 0, 1, 8'd1, 5'd9);
        rd_reg(5'h04); chk("R12 DOWN bit survives eject", rd, 32'h200);

        // R14 events on missing buses dropped
        cyc(0, 0, 1, 0, 0, 1, 8'd7, 5'd1, 1, 8'd200, 5'd1);
        chk("R14 no irq", {31'b0, s_irq}, 0);

        // R8 legacy pins selection to bus 0
        cfg_legacy = 1'b1;
        wr_reg(5'h10, 32'd2);
        rd_reg(5'h10); chk("R8 legacy select", rd, 0);
        cfg_legacy = 1'b0;
        wr_reg(5'h10, 32'd2);
        rd_reg(5'h10); chk("R7 normal select", rd, 2);

        // R1 unmapped offset reads zero
        rd_reg(5'h14); chk("R1 unmapped", rd, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule